// File: doc/BRIEF.md
# Character Row Vertical Scaler

This block produces the vertical timing of a character overlay frame of 15 text rows. It watches the incoming horizontal and vertical sync strobes, which it samples on the system clock. After a programmable number of scan lines from the vertical sync, it walks down the frame one scan line per horizontal sync. For every displayed scan line it reports which character row is being painted and which of the 18 native glyph lines the font fetch should read.

A glyph is made taller than its native 18 lines by showing selected glyph lines more than once. A two-bit multiplier field shows every line one, two or three times. A five-bit extra field adds one more showing to a fixed, evenly spread set of lines. Each row can also be doubled in height. Each row can be followed by a band of blank spacing lines. A slow blink phase flips every 32 frames for the attribute logic downstream.

Top module: `char_row_vscaler`

## Requirements
- R1: A sync leading edge is a transition of the sampled sync input into its asserted level: rising when `sync_pol`=1, falling when `sync_pol`=0. Any other transition is ignored.
- R2: After a vertical leading edge, the first displayed scan line (row 0, glyph line 0) starts at horizontal leading edge number `vstart`*4+1. With `vstart`=0 this is the first edge after the vertical sync.
- R3: `height_code[6:5]` sets a base multiplier: 00 or 01 show each glyph line once (18 lines), 10 twice (36), 11 three times (54).
- R4: `height_code[4:0]` is clamped to 17 when 17 or larger, and each of its bits adds one more showing of a fixed set of glyph lines. Bit0 adds line 16. Bit1 adds lines 4 and 13. Bit2 adds lines 2, 6, 11 and 15. Bit3 adds lines 0, 3, 5, 7, 8, 10, 12 and 14. Bit4 adds lines 0 to 15. The glyph lines of a row are walked in ascending order.
- R5: When `row_dbl[r]` is 1, every scan line of row r, including repeated lines, is shown on two consecutive scan lines.
- R6: After glyph line 17 of each row, `row_space` blank lines follow with `font_line`=18 and `disp_active` high.
- R7: After the spacing of row 14, `disp_active` falls and stays low until the next vertical leading edge. A vertical leading edge at any time abandons the current frame and restarts the start delay.
- R8: `blink_phase` toggles on every 32nd vertical leading edge and changes at no other time.
- R9: After reset, `disp_active`=0, `row_idx`=0, `font_line`=0 and `blink_phase`=0.
- R10: While `disp_active` is low, `row_idx` and `font_line` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync level |
| vsync_in | input | 1 | Vertical sync level |
| sync_pol | input | 1 | 1: positive syncs, 0: negative syncs |
| vstart | input | 8 | Start delay in steps of 4 scan lines |
| height_code | input | 7 | Character height code |
| row_space | input | 5 | Blank lines appended below each row |
| row_dbl | input | 15 | Per-row double-height flags, bit r for row r |
| disp_active | output | 1 | Current scan line belongs to the frame |
| row_idx | output | 4 | Current character row, 0 to 14 |
| font_line | output | 5 | Glyph line 0 to 17, or 18 on a spacing line |
| blink_phase | output | 1 | Blink phase, flips every 32 frames |

## Verification
Every cycle, the assertions check that outputs move only after a sync leading edge and that the row index advances by at most one while displaying. They also check that a vertical edge closes the display, that the blink phase changes only on a vertical edge, and that the idle outputs and the index ranges are respected. Other properties need whole frames to observe: the exact order of repeated glyph lines for a given height code, the clamp of the extra field, doubling and spacing, and the length of the start delay. The bench's scenarios show these by comparing each line against a frame list built from the requirements and by counting displayed lines per frame.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

    localparam int GLYPH_LINES = 18;
    localparam int ROWS        = 15;
    localparam int LINE_W      = $clog2(GLYPH_LINES + 1);
    localparam int ROW_W       = $clog2(ROWS);
    localparam int VSTART_W    = 8;
    localparam int DLY_W       = VSTART_W + 2;
    localparam int SPC_W       = 5;
    localparam int CODE_W      = 7;
    localparam int EXTRA_W     = 5;
    localparam int EXTRA_MAX   = GLYPH_LINES - 1;
    localparam int REP_W       = 2;
    localparam int REPS_W      = 3;

    localparam logic [LINE_W-1:0] BLANK_LINE = LINE_W'(GLYPH_LINES);

    // glyph line sets repeated once by each bit of the extra field
    localparam logic [GLYPH_LINES-1:0] SET_B0 = 18'h10000;
    localparam logic [GLYPH_LINES-1:0] SET_B1 = 18'h02010;
    localparam logic [GLYPH_LINES-1:0] SET_B2 = 18'h08844;
    localparam logic [GLYPH_LINES-1:0] SET_B3 = 18'h055A9;
    localparam logic [GLYPH_LINES-1:0] SET_B4 = 18'h0FFFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DELAY,
        PH_SHOW,
        PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [DLY_W-1:0]    dly;
        logic [ROW_W-1:0]    row;
        logic [LINE_W-1:0]   gline;
        logic [REP_W-1:0]    rep;
        logic                dbl;
        logic                in_space;
        logic [SPC_W-1:0]    spc;
        logic                active;
    } vs_state_t;

endpackage

// File: rtl/vscale_edge.sv
module vscale_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic pol,
    output logic lead_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
        lead_o = pol ? (sig_in & ~prev_q) : (~sig_in & prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/vscale_reps.sv
module vscale_reps
    import vscale_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [LINE_W-1:0] line,
    output logic [REPS_W-1:0] reps
);
    logic [EXTRA_W-1:0]     extra;
    logic [GLYPH_LINES-1:0] mask;
    logic [REPS_W-1:0]      mult;
    logic                   hit;

    always_comb begin
        extra = (code[EXTRA_W-1:0] >= EXTRA_W'(EXTRA_MAX)) ?
                EXTRA_W'(EXTRA_MAX) : code[EXTRA_W-1:0];
        mask = ({GLYPH_LINES{extra[0]}} & SET_B0) |
               ({GLYPH_LINES{extra[1]}} & SET_B1) |
               ({GLYPH_LINES{extra[2]}} & SET_B2) |
               ({GLYPH_LINES{extra[3]}} & SET_B3) |
               ({GLYPH_LINES{extra[4]}} & SET_B4);
        case (code[CODE_W-1:CODE_W-2])
            2'b11:   mult = REPS_W'(3);
            2'b10:   mult = REPS_W'(2);
            default: mult = REPS_W'(1);
        endcase
        hit = 1'b0;
        for (int i = 0; i < GLYPH_LINES; i++) begin
            if (line == LINE_W'(i)) hit = mask[i];
        end
        reps = mult + REPS_W'(hit);
    end
endmodule

// File: rtl/vscale_blink.sv
module vscale_blink #(
    parameter int FRAMES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    output logic phase_o
);
    localparam int CNT_W = $clog2(FRAMES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ph;
    } blink_t;

    blink_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (frame_tick) begin
            if (b_q.cnt == CNT_W'(FRAMES - 1)) begin
                b_d.cnt = '0;
                b_d.ph  = ~b_q.ph;
            end else begin
                b_d.cnt = b_q.cnt + 1'b1;
            end
        end
        phase_o = b_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end
endmodule

// File: rtl/char_row_vscaler.sv
module char_row_vscaler
    import vscale_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsync_in,
    input  logic                vsync_in,
    input  logic                sync_pol,
    input  logic [7:0]          vstart,
    input  logic [6:0]          height_code,
    input  logic [4:0]          row_space,
    input  logic [14:0]         row_dbl,
    output logic                disp_active,
    output logic [3:0]          row_idx,
    output logic [4:0]          font_line,
    output logic                blink_phase
);
    logic hs_edge, vs_edge;
    logic [REPS_W-1:0] cur_reps;
    logic cur_dbl;
    logic row_done;
    vs_state_t s_d, s_q;

    vscale_edge u_hs (.clk(clk), .rst_n(rst_n), .sig_in(hsync_in),
                      .pol(sync_pol), .lead_o(hs_edge));
    vscale_edge u_vs (.clk(clk), .rst_n(rst_n), .sig_in(vsync_in),
                      .pol(sync_pol), .lead_o(vs_edge));

    vscale_reps u_reps (.code(height_code), .line(s_q.gline), .reps(cur_reps));

    vscale_blink #(.FRAMES(32)) u_blink (.clk(clk), .rst_n(rst_n),
                      .frame_tick(vs_edge), .phase_o(blink_phase));

    always_comb begin
        s_d      = s_q;
        row_done = 1'b0;
        cur_dbl  = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            if (s_q.row == ROW_W'(r)) cur_dbl = row_dbl[r];
        end

        if (vs_edge) begin
            s_d       = '0;
            s_d.phase = PH_DELAY;
            s_d.dly   = {vstart, 2'b00} + DLY_W'(1);
        end else if (hs_edge) begin
            case (s_q.phase)
                PH_DELAY: begin
                    if (s_q.dly == DLY_W'(1)) begin
                        s_d.phase  = PH_SHOW;
                        s_d.active = 1'b1;
                        s_d.dly    = '0;
                    end else begin
                        s_d.dly = s_q.dly - 1'b1;
                    end
                end
                PH_SHOW: begin
                    if (s_q.in_space) begin
                        if (s_q.spc == SPC_W'(row_space - 1'b1)) row_done = 1'b1;
                        else s_d.spc = s_q.spc + 1'b1;
                    end else if (cur_dbl && !s_q.dbl) begin
                        s_d.dbl = 1'b1;
                    end else begin
                        s_d.dbl = 1'b0;
                        if (REPS_W'(s_q.rep) + REPS_W'(1) < cur_reps) begin
                            s_d.rep = s_q.rep + 1'b1;
                        end else begin
                            s_d.rep = '0;
                            if (s_q.gline == LINE_W'(GLYPH_LINES - 1)) begin
                                if (row_space != '0) begin
                                    s_d.in_space = 1'b1;
                                    s_d.spc      = '0;
                                end else begin
                                    row_done = 1'b1;
                                end
                            end else begin
                                s_d.gline = s_q.gline + 1'b1;
                            end
                        end
                    end
                    if (row_done) begin
                        s_d.in_space = 1'b0;
                        s_d.spc      = '0;
                        s_d.gline    = '0;
                        s_d.rep      = '0;
                        s_d.dbl      = 1'b0;
                        if (s_q.row == ROW_W'(ROWS - 1)) begin
                            s_d.phase  = PH_DONE;
                            s_d.active = 1'b0;
                            s_d.row    = '0;
                        end else begin
                            s_d.row = s_q.row + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        disp_active = s_q.active;
        row_idx     = s_q.row;
        font_line   = s_q.in_space ? BLANK_LINE : s_q.gline;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/vscale_checks.sv
module vscale_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_edge,
    input logic       vs_edge,
    input logic       disp_active,
    input logic [3:0] row_idx,
    input logic [4:0] font_line,
    input logic       blink_phase
);
    assert_row_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx < 4'd15);

    assert_line_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        font_line <= 5'd18);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_active |-> (row_idx == 4'd0 && font_line == 5'd0));

    assert_vsync_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge |=> !disp_active);

    assert_moves_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(font_line) || !$stable(disp_active) || !$stable(row_idx))
            |-> $past(hs_edge || vs_edge));

    assert_blink_on_vsync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blink_phase) |-> $past(vs_edge));

    assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && $past(disp_active)) |->
            (row_idx == $past(row_idx) || row_idx == $past(row_idx) + 4'd1));
endmodule

bind char_row_vscaler vscale_checks u_checks (
    .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .vs_edge(vs_edge),
    .disp_active(disp_active), .row_idx(row_idx), .font_line(font_line),
    .blink_phase(blink_phase)
);

// File: tb/char_row_vscaler_test.sv
`timescale 1ns/1ps
module char_row_vscaler_test;
    logic clk = 0;
    logic rst_n = 0;
    logic hs = 0, vs = 0, pol = 1;
    logic [7:0]  vst = 0;
    logic [6:0]  hc = 0;
    logic [4:0]  rsp = 0;
    logic [14:0] dbl = 0;
    logic        act, blk;
    logic [3:0]  row;
    logic [4:0]  fl;

    always #2.5 clk = ~clk;

    char_row_vscaler uut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .sync_pol(pol),
        .vstart(vst), .height_code(hc), .row_space(rsp), .row_dbl(dbl),
        .disp_active(act), .row_idx(row), .font_line(fl), .blink_phase(blk)
    );

    int total = 0, bad = 0;
    string cur_req = "R9";
    bit cmp_en = 0;
    int frames = 0;

    // ---------- behavioural reference ----------
    int q[$];
    int m_dly = 0, m_show = 0, m_row = 0, m_fl = 0, m_act = 0, m_vcnt = 0;
    logic hp = 0, vp = 0;

    function automatic int extra_hit(int code, int g);
        int c = code & 31;
        int h = 0;
        if (c > 17) c = 17;
        if ((c & 1)  && g == 16) h = 1;
        if ((c & 2)  && (g inside {4, 13})) h = 1;
        if ((c & 4)  && (g inside {2, 6, 11, 15})) h = 1;
        if ((c & 8)  && (g inside {0, 3, 5, 7, 8, 10, 12, 14})) h = 1;
        if ((c & 16) && g <= 15) h = 1;
        return h;
    endfunction

    function automatic int mult_of(int code);
        int t = (code >> 5) & 3;
        return (t == 3) ? 3 : (t == 2) ? 2 : 1;
    endfunction

    task automatic build_frame();
        q.delete();
        for (int r = 0; r < 15; r++) begin
            for (int g = 0; g < 18; g++) begin
                for (int k = 0; k < mult_of(hc) + extra_hit(hc, g); k++) begin
                    for (int d = 0; d < (dbl[r] ? 2 : 1); d++) q.push_back(r * 32 + g);
                end
            end
            for (int s = 0; s < rsp; s++) q.push_back(r * 32 + 18);
        end
    endtask

    task automatic pop_line();
        int e = q.pop_front();
        m_row = e / 32; m_fl = e % 32; m_act = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            hp = 0; vp = 0; m_dly = 0; m_show = 0; m_row = 0; m_fl = 0; m_act = 0; m_vcnt = 0;
        end else begin
            bit he, ve;
            he = pol ? (hs && !hp) : (!hs && hp);
            ve = pol ? (vs && !vp) : (!vs && vp);
            hp = hs; vp = vs;
            if (ve) begin
                m_vcnt++;
                build_frame();
                m_dly = vst * 4 + 1; m_show = 0; m_act = 0; m_row = 0; m_fl = 0;
            end else if (he) begin
                if (m_dly > 0) begin
                    m_dly--;
                    if (m_dly == 0) begin m_show = 1; pop_line(); end
                end else if (m_show) begin
                    if (q.size() > 0) pop_line();
                    else begin m_show = 0; m_act = 0; m_row = 0; m_fl = 0; end
                end
            end
        end
    end

    task automatic check(string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("disp_active", act, m_act);
            check("row_idx", row, m_row);
            check("font_line", fl, m_fl);
            check("blink_phase", blk, (m_vcnt / 32) % 2);
        end
    end

    // ---------- stimulus ----------
    task automatic set_pol(logic p);
        @(negedge clk); pol = p; hs = !p; vs = !p;
        @(negedge clk);
    endtask

    task automatic hs_pulse(inout int cnt);
        @(negedge clk); hs = pol;
        @(negedge clk); if (act) cnt++; hs = !pol;
        @(negedge clk);
    endtask

    function automatic int frame_len();
        int n = 0;
        int h = 18 * mult_of(hc) + (((hc & 31) > 17) ? 17 : (hc & 31));
        for (int r = 0; r < 15; r++) n += h * (dbl[r] ? 2 : 1) + rsp;
        return n;
    endfunction

    task automatic run_frame(int extra_lines, bit full);
        int cnt = 0;
        int n;
        @(negedge clk); vs = pol;
        @(negedge clk); vs = !pol;
        @(negedge clk);
        frames++;
        // R8: phase after this vertical edge
        check("blink after vsync (R8)", blk, (frames / 32) % 2);
        check("inactive after vsync (R7)", act, 0);
        n = full ? (vst * 4 + 1 + frame_len() + extra_lines) : extra_lines;
        for (int i = 0; i < n; i++) hs_pulse(cnt);
        if (full) check("displayed line count", cnt, frame_len());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("reset disp_active (R9)", act, 0);
        check("reset row_idx (R9)", row, 0);
        check("reset font_line (R9)", fl, 0);
        check("reset blink_phase (R9)", blk, 0);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;

        // R3, R1: positive syncs, base height, no delay steps
        cur_req = "R3";
        pol = 1; vst = 0; hc = 7'h00; rsp = 0; dbl = 0;
        hs_pulse(total); total--; // lines before any vsync must be ignored (R10)
        run_frame(6, 1);

        // R1, R2, R4, R6: negative syncs, default delay, extra lines and spacing
        cur_req = "R4";
        set_pol(0);
        vst = 4; hc = 7'h28; rsp = 3; dbl = 0;
        run_frame(4, 1);

        // R5: double height rows with tallest glyph and largest spacing
        cur_req = "R5";
        vst = 1; hc = 7'h7F; rsp = 31; dbl = 15'h5555;
        run_frame(3, 1);

        // R4 clamp with x2 base, R1 back to positive
        cur_req = "R4";
        set_pol(1);
        vst = 2; hc = 7'h51; rsp = 1; dbl = 15'h4001;
        run_frame(3, 1);

        // R2: largest start delay, R6 with zero spacing
        cur_req = "R2";
        vst = 255; hc = 7'h12; rsp = 0; dbl = 0;
        run_frame(2, 1);

        // R6: spacing lines carry blank index
        cur_req = "R6";
        vst = 0; hc = 7'h01; rsp = 5; dbl = 15'h0002;
        run_frame(4, 1);

        // R7, R8: truncated frames restart on every vertical edge, blink over 32 frames
        cur_req = "R8";
        vst = 0; hc = 7'h00; rsp = 2; dbl = 0;
        for (int f = 0; f < 30; f++) run_frame(25, 0);
        cur_req = "R7";
        run_frame(5, 1);

        cmp_en = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog %s: got 0 expected 1", cur_req);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule